// File: doc/BRIEF.md
# Memory-to-Memory Cipher Job Controller

This block runs block-cipher jobs between buffers in memory on behalf of software. Software fills a handful of 64-bit registers through a simple register port: where the key sits, where the source buffer sits, where results go and how many 128-bit blocks to process. It then writes a command code. The controller then moves the data over a 64-bit word master port and hands each 128-bit block to an external cipher core through a valid/ready pair. The core's round logic lies outside this block.

Three commands exist. The first loads a key: it reads two words from the key address and passes them to the core as a set-key operation. The second encrypts and the third decrypts: each block of the source buffer goes through the core and lands at the same offset in the destination buffer. Software learns that a job has finished either by polling the status register or through a level interrupt. Misuse is reported through an error status rather than acted on.

Top module: `cipher_job_engine`

## Requirements
- R1: Register offsets are key address 0x00, source address 0x08, destination address 0x10, block count 0x18 (low CNT_W bits kept), command 0x20 and status 0x28. The four address/count registers read back what was written. The command offset reads as zero.
- R2: Status reads 2 when the error flag is set, otherwise 1 while a job runs, otherwise 0.
- R3: Command code 1 (load key) reads the word at the key address as bits 63:0 and the word at key address + 8 as bits 127:64. It issues exactly these two reads and passes the 128-bit value to the core with operation code 0.
- R4: Command codes 2 (encrypt) and 3 (decrypt) take block i from source + 16*i (low half at the lower address). They pass it to the core and write the core's 128-bit result to destination + 16*i, low half first. Each block uses exactly four memory transfers. No request or core operation is issued while idle.
- R5: A command written while a job runs is ignored and sets the error flag. The running job still completes with correct results.
- R6: Encrypt or decrypt before any completed key load is ignored, causes no memory traffic and sets the error flag.
- R7: A command code other than 1, 2 or 3 is ignored and sets the error flag.
- R8: Encrypt or decrypt with a block count of zero finishes at once: the interrupt is high one cycle after the command write, no memory traffic occurs, and the status is 0.
- R9: The interrupt rises when a job completes and stays high until a status read or a command write clears it.
- R10: Memory requests are one at a time: a request holds its address and direction until granted, and read data is taken from the response strobe.
- R11: Core operation codes are 0 set-key, 1 encrypt and 2 decrypt. The valid strobe, data and operation stay stable until the core accepts them.
- R12: An accepted command clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read data is combinational) |
| regAddr | input | REG_AW | Register byte offset |
| regWrData | input | WORD_W | Register write data |
| regRdData | output | WORD_W | Register read data |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | WORD_W | Byte address of the 64-bit word |
| memWData | output | WORD_W | Write data |
| memGnt | input | 1 | Memory accepts the request this cycle |
| memRValid | input | 1 | Read data valid, earliest one cycle after grant |
| memRData | input | WORD_W | Read data |
| coreValid | output | 1 | Operation offered to the cipher core |
| coreOp | output | 2 | Core operation code |
| coreData | output | 2*WORD_W | Key or block for the core |
| coreReady | input | 1 | Core accepts the operation |
| coreRespValid | input | 1 | Core result strobe |
| coreRespData | input | 2*WORD_W | Core result block |
| irq | output | 1 | Completion interrupt level |

## Verification
The bound checker watches the handshake rules on every cycle. A memory request or a core operation may not change before it is accepted. Nothing is issued while idle, and memory and core requests never overlap. A command written during a job must leave the error flag set, and the interrupt may not drop without a clear. The bench scenarios are the only evidence for data correctness: half-word ordering, per-block offsets, decrypt undoing encrypt and the key reaching the core. They also show the register readback, the zero-count shortcut and the absence of traffic on rejected commands. A stand-in core with a reversible transform and a memory model with stalls supply these scenarios.

// File: rtl/cipher_job_pkg.sv
package cipher_job_pkg;

  localparam int CMD_LOAD_KEY = 1;
  localparam int CMD_ENCRYPT  = 2;
  localparam int CMD_DECRYPT  = 3;

  localparam logic [1:0] OP_SETKEY = 2'd0;
  localparam logic [1:0] OP_ENC    = 2'd1;
  localparam logic [1:0] OP_DEC    = 2'd2;

  localparam logic [1:0] STAT_IDLE = 2'd0;
  localparam logic [1:0] STAT_BUSY = 2'd1;
  localparam logic [1:0] STAT_ERR  = 2'd2;

  localparam int OFF_KEY    = 'h00;
  localparam int OFF_SRC    = 'h08;
  localparam int OFF_DST    = 'h10;
  localparam int OFF_COUNT  = 'h18;
  localparam int OFF_CMD    = 'h20;
  localparam int OFF_STATUS = 'h28;

  typedef struct packed {
    logic jobStart;
    logic useKey;
    logic latchLo;
    logic latchHi;
    logic latchOut;
    logic nextBlock;
  } dp_ctrl_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_LO, S_RD_LO_W, S_RD_HI, S_RD_HI_W,
    S_CORE, S_CORE_W, S_WR_LO, S_WR_HI
  } job_state_t;

endpackage

// File: rtl/cipher_job_dp.sv
module cipher_job_dp
  import cipher_job_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic [WORD_W-1:0]     regWrData,
  output logic [WORD_W-1:0]     regRdData,
  input  logic [1:0]            statusCode,
  input  dp_ctrl_t              ctl,
  input  logic                  hiHalf,
  input  logic                  useWrPtr,
  output logic [WORD_W-1:0]     memAddr,
  output logic [WORD_W-1:0]     memWData,
  input  logic [WORD_W-1:0]     memRData,
  output logic [2*WORD_W-1:0]   coreData,
  input  logic [2*WORD_W-1:0]   coreRespData,
  output logic                  cntZero,
  output logic                  lastBlock
);

  localparam int BLOCK_W     = 2 * WORD_W;
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int BLOCK_BYTES = BLOCK_W / 8;

  logic [WORD_W-1:0]  keyAddrR, srcAddrR, dstAddrR;
  logic [CNT_W-1:0]   countR, blocksLeft;
  logic [WORD_W-1:0]  rdPtr, wrPtr;
  logic [BLOCK_W-1:0] blockR;

  // programmed registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyAddrR <= '0;
      srcAddrR <= '0;
      dstAddrR <= '0;
      countR   <= '0;
    end else if (regWrEn) begin
      case (int'(regAddr))
        OFF_KEY:   keyAddrR <= regWrData;
        OFF_SRC:   srcAddrR <= regWrData;
        OFF_DST:   dstAddrR <= regWrData;
        OFF_COUNT: countR   <= regWrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (int'(regAddr))
      OFF_KEY:    regRdData = keyAddrR;
      OFF_SRC:    regRdData = srcAddrR;
      OFF_DST:    regRdData = dstAddrR;
      OFF_COUNT:  regRdData = WORD_W'(countR);
      OFF_STATUS: regRdData = WORD_W'(statusCode);
      default:    regRdData = '0;
    endcase
  end

  // working pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr      <= '0;
      wrPtr      <= '0;
      blocksLeft <= '0;
    end else if (ctl.jobStart) begin
      rdPtr      <= ctl.useKey ? keyAddrR : srcAddrR;
      wrPtr      <= dstAddrR;
      blocksLeft <= ctl.useKey ? CNT_W'(1) : countR;
    end else if (ctl.nextBlock) begin
      rdPtr      <= rdPtr + WORD_W'(BLOCK_BYTES);
      wrPtr      <= wrPtr + WORD_W'(BLOCK_BYTES);
      blocksLeft <= blocksLeft - CNT_W'(1);
    end
  end

  // block buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockR <= '0;
    end else if (ctl.latchLo) begin
      blockR[WORD_W-1:0] <= memRData;
    end else if (ctl.latchHi) begin
      blockR[BLOCK_W-1:WORD_W] <= memRData;
    end else if (ctl.latchOut) begin
      blockR <= coreRespData;
    end
  end

  assign memAddr   = (useWrPtr ? wrPtr : rdPtr) + (hiHalf ? WORD_W'(WORD_BYTES) : '0);
  assign memWData  = hiHalf ? blockR[BLOCK_W-1:WORD_W] : blockR[WORD_W-1:0];
  assign coreData  = blockR;
  assign cntZero   = (countR == '0);
  assign lastBlock = (blocksLeft == CNT_W'(1));

endmodule

// File: rtl/cipher_job_ctrl.sv
module cipher_job_ctrl
  import cipher_job_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [WORD_W-1:0] cmdCode,
  input  logic              statusRd,
  input  logic              cntZero,
  input  logic              lastBlock,
  input  logic              memGnt,
  input  logic              memRValid,
  input  logic              coreReady,
  input  logic              coreRespValid,
  output dp_ctrl_t          ctl,
  output logic              hiHalf,
  output logic              useWrPtr,
  output logic              memReq,
  output logic              memWe,
  output logic              coreValid,
  output logic [1:0]        coreOp,
  output logic              irq,
  output logic              busy,
  output logic              errFlag,
  output logic [1:0]        statusCode
);

  job_state_t state, stateNxt;
  logic [1:0] opR;
  logic       keyValid;
  logic       isLoadKey, isEnc, isDec, knownCmd;
  logic       accept, reject, zeroDone, startJob, jobDone;

  assign isLoadKey = (cmdCode == WORD_W'(CMD_LOAD_KEY));
  assign isEnc     = (cmdCode == WORD_W'(CMD_ENCRYPT));
  assign isDec     = (cmdCode == WORD_W'(CMD_DECRYPT));
  assign knownCmd  = isLoadKey | isEnc | isDec;

  assign busy     = (state != S_IDLE);
  assign accept   = cmdWr && !busy && knownCmd && (isLoadKey || keyValid);
  assign reject   = cmdWr && !accept;
  assign zeroDone = accept && !isLoadKey && cntZero;
  assign startJob = accept && !zeroDone;

  always_comb begin
    stateNxt     = state;
    ctl          = '0;
    ctl.jobStart = startJob;
    ctl.useKey   = isLoadKey;
    hiHalf       = 1'b0;
    useWrPtr     = 1'b0;
    memReq       = 1'b0;
    memWe        = 1'b0;
    coreValid    = 1'b0;
    jobDone      = 1'b0;
    case (state)
      S_IDLE: if (startJob) stateNxt = S_RD_LO;
      S_RD_LO: begin
        memReq = 1'b1;
        if (memGnt) stateNxt = S_RD_LO_W;
      end
      S_RD_LO_W: if (memRValid) begin
        ctl.latchLo = 1'b1;
        stateNxt    = S_RD_HI;
      end
      S_RD_HI: begin
        memReq = 1'b1;
        hiHalf = 1'b1;
        if (memGnt) stateNxt = S_RD_HI_W;
      end
      S_RD_HI_W: if (memRValid) begin
        ctl.latchHi = 1'b1;
        stateNxt    = S_CORE;
      end
      S_CORE: begin
        coreValid = 1'b1;
        if (coreReady) stateNxt = S_CORE_W;
      end
      S_CORE_W: if (coreRespValid) begin
        if (opR == OP_SETKEY) begin
          jobDone  = 1'b1;
          stateNxt = S_IDLE;
        end else begin
          ctl.latchOut = 1'b1;
          stateNxt     = S_WR_LO;
        end
      end
      S_WR_LO: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        useWrPtr = 1'b1;
        if (memGnt) stateNxt = S_WR_HI;
      end
      S_WR_HI: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        useWrPtr = 1'b1;
        hiHalf   = 1'b1;
        if (memGnt) begin
          ctl.nextBlock = 1'b1;
          if (lastBlock) begin
            jobDone  = 1'b1;
            stateNxt = S_IDLE;
          end else begin
            stateNxt = S_RD_LO;
          end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      opR      <= OP_SETKEY;
      keyValid <= 1'b0;
      errFlag  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      state <= stateNxt;
      if (startJob)
        opR <= isLoadKey ? OP_SETKEY : (isEnc ? OP_ENC : OP_DEC);
      if (jobDone && opR == OP_SETKEY)
        keyValid <= 1'b1;
      if (reject)
        errFlag <= 1'b1;
      else if (accept)
        errFlag <= 1'b0;
      if (jobDone || zeroDone)
        irq <= 1'b1;
      else if (cmdWr || statusRd)
        irq <= 1'b0;
    end
  end

  assign coreOp     = opR;
  assign statusCode = errFlag ? STAT_ERR : (busy ? STAT_BUSY : STAT_IDLE);

endmodule

// File: rtl/cipher_job_engine.sv
module cipher_job_engine
  import cipher_job_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regRdData,
  output logic                memReq,
  output logic                memWe,
  output logic [WORD_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memWData,
  input  logic                memGnt,
  input  logic                memRValid,
  input  logic [WORD_W-1:0]   memRData,
  output logic                coreValid,
  output logic [1:0]          coreOp,
  output logic [2*WORD_W-1:0] coreData,
  input  logic                coreReady,
  input  logic                coreRespValid,
  input  logic [2*WORD_W-1:0] coreRespData,
  output logic                irq
);

  dp_ctrl_t   ctl;
  logic       hiHalf, useWrPtr, cntZero, lastBlock;
  logic       busy, errFlag, cmdWr, statusRd;
  logic [1:0] statusCode;

  assign cmdWr    = regWrEn && (int'(regAddr) == OFF_CMD);
  assign statusRd = regRdEn && (int'(regAddr) == OFF_STATUS);

  cipher_job_ctrl #(.WORD_W(WORD_W)) ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdCode(regWrData),
    .statusRd(statusRd), .cntZero(cntZero), .lastBlock(lastBlock),
    .memGnt(memGnt), .memRValid(memRValid), .coreReady(coreReady),
    .coreRespValid(coreRespValid), .ctl(ctl), .hiHalf(hiHalf),
    .useWrPtr(useWrPtr), .memReq(memReq), .memWe(memWe),
    .coreValid(coreValid), .coreOp(coreOp), .irq(irq), .busy(busy),
    .errFlag(errFlag), .statusCode(statusCode)
  );

  cipher_job_dp #(.WORD_W(WORD_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .statusCode(statusCode),
    .ctl(ctl), .hiHalf(hiHalf), .useWrPtr(useWrPtr), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData), .coreData(coreData),
    .coreRespData(coreRespData), .cntZero(cntZero), .lastBlock(lastBlock)
  );

endmodule

// File: rtl/cipher_job_checks.sv
module cipher_job_checks
  import cipher_job_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int REG_AW = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic                regRdEn,
  input logic [REG_AW-1:0]   regAddr,
  input logic                memReq,
  input logic                memWe,
  input logic [WORD_W-1:0]   memAddr,
  input logic                memGnt,
  input logic                coreValid,
  input logic [1:0]          coreOp,
  input logic [2*WORD_W-1:0] coreData,
  input logic                coreReady,
  input logic                busy,
  input logic                errFlag,
  input logic                irq
);

  logic cmdSeen, clrSeen;
  assign cmdSeen = regWrEn && (int'(regAddr) == OFF_CMD);
  assign clrSeen = cmdSeen || (regRdEn && (int'(regAddr) == OFF_STATUS));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWe));

  assert_core_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    coreValid && !coreReady |=> coreValid && $stable(coreData) && $stable(coreOp));

  assert_core_opcode_R11: assert property (@(posedge clk) disable iff (!rstN)
    coreValid |-> coreOp != 2'd3);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !coreValid);

  assert_single_request_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && coreValid));

  assert_busy_cmd_error_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdSeen && busy |=> errFlag);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq && !clrSeen |=> irq);

endmodule

bind cipher_job_engine cipher_job_checks #(.WORD_W(WORD_W), .REG_AW(REG_AW)) chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memGnt(memGnt), .coreValid(coreValid), .coreOp(coreOp),
  .coreData(coreData), .coreReady(coreReady), .busy(busy),
  .errFlag(errFlag), .irq(irq)
);

// File: tb/cipher_job_engine_test.sv
module cipher_job_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 64;
  localparam int REG_AW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [REG_AW-1:0] regAddr = '0;
  logic [WORD_W-1:0] regWrData = '0;
  logic [WORD_W-1:0] regRdData;
  logic memReq, memWe, memGnt, memRValid;
  logic [WORD_W-1:0] memAddr, memWData, memRData;
  logic coreValid, coreReady, coreRespValid;
  logic [1:0] coreOp;
  logic [127:0] coreData, coreRespData;
  logic irq;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_job_engine uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memGnt(memGnt), .memRValid(memRValid), .memRData(memRData),
    .coreValid(coreValid), .coreOp(coreOp), .coreData(coreData),
    .coreReady(coreReady), .coreRespValid(coreRespValid),
    .coreRespData(coreRespData), .irq(irq)
  );

  // ---------------- memory and core stand-ins ----------------
  logic [63:0] mem [0:127];
  logic [31:0] cyc = 0;
  int txCount = 0;
  logic [127:0] coreKey = '0;
  logic [1:0] lastOp = 2'd3;
  logic [1:0] respDelay = 2'd0;
  logic [127:0] respData = '0;
  logic rv = 1'b0;
  logic [63:0] rd = '0;

  function automatic logic [127:0] swapHalves(input logic [127:0] x);
    return {x[63:0], x[127:64]};
  endfunction
  function automatic logic [127:0] encF(input logic [127:0] x, input logic [127:0] k);
    return swapHalves(x) ^ k;
  endfunction
  function automatic logic [127:0] decF(input logic [127:0] x, input logic [127:0] k);
    return swapHalves(x ^ k);
  endfunction

  assign memGnt        = memReq && (cyc[2:0] != 3'd3);
  assign memRValid     = rv;
  assign memRData      = rd;
  assign coreReady     = (cyc[1:0] != 2'd0) && (respDelay == 2'd0);
  assign coreRespValid = (respDelay == 2'd1);
  assign coreRespData  = respData;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rv  <= memReq && memGnt && !memWe;
    if (memReq && memGnt) begin
      txCount <= txCount + 1;
      if (memWe) mem[memAddr[9:3]] <= memWData;
      else       rd <= mem[memAddr[9:3]];
    end
    if (respDelay != 2'd0) respDelay <= respDelay - 2'd1;
    if (coreValid && coreReady) begin
      lastOp    <= coreOp;
      respDelay <= 2'd2;
      case (coreOp)
        2'd0: begin coreKey <= coreData; respData <= '0; end
        2'd1: respData <= encF(coreData, coreKey);
        default: respData <= decF(coreData, coreKey);
      endcase
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input int off, input logic [63:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = REG_AW'(off); regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input int off, output logic [63:0] val);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = REG_AW'(off);
    #1 val = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitIrq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
    end
  endtask

  task automatic setupJob(input logic [63:0] src, input logic [63:0] dst, input int n);
    regWrite('h08, src);
    regWrite('h10, dst);
    regWrite('h18, 64'(n));
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    logic [63:0] v;
    check(irq == 1'b0, "R9 irq low after reset", 128'(irq), 0);
    check(memReq == 1'b0 && coreValid == 1'b0, "R4 quiet after reset", 128'({memReq, coreValid}), 0);
    regRead('h28, v);
    check(v == 0, "R2 status idle after reset", 128'(v), 0);
    regRead('h00, v);
    check(v == 0, "R1 key address resets to zero", 128'(v), 0);
  endtask

  task automatic testRegisters();
    logic [63:0] v;
    regWrite('h00, 64'h1111_2222_3333_4440);
    regWrite('h08, 64'h0000_0000_0000_0100);
    regWrite('h10, 64'h0000_0000_0000_0200);
    regWrite('h18, 64'h0000_0000_0001_0005);
    regRead('h00, v); check(v == 64'h1111_2222_3333_4440, "R1 key address readback", 128'(v), 128'h1111_2222_3333_4440);
    regRead('h08, v); check(v == 64'h100, "R1 source readback", 128'(v), 128'h100);
    regRead('h10, v); check(v == 64'h200, "R1 destination readback", 128'(v), 128'h200);
    regRead('h18, v); check(v == 64'h5, "R1 count keeps low bits", 128'(v), 128'h5);
    regRead('h20, v); check(v == 0, "R1 command reads zero", 128'(v), 0);
  endtask

  task automatic testNoKey();
    logic [63:0] v;
    int tx0;
    setupJob(64'h100, 64'h200, 1);
    tx0 = txCount;
    regWrite('h20, 64'd2);
    repeat (20) @(negedge clk);
    regRead('h28, v);
    check(v == 2, "R6 encrypt without key gives error", 128'(v), 2);
    check(txCount == tx0, "R6 no traffic without key", 128'(txCount), 128'(tx0));
    check(irq == 1'b0, "R6 no interrupt on rejected command", 128'(irq), 0);
  endtask

  task automatic testBadCode();
    logic [63:0] v;
    int tx0;
    tx0 = txCount;
    regWrite('h20, 64'd7);
    repeat (10) @(negedge clk);
    regRead('h28, v);
    check(v == 2, "R7 unknown code gives error", 128'(v), 2);
    check(txCount == tx0, "R7 unknown code causes no traffic", 128'(txCount), 128'(tx0));
  endtask

  task automatic testLoadKey();
    logic [63:0] v;
    bit seen;
    int tx0;
    mem[0] = 64'h0123_4567_89ab_cdef;
    mem[1] = 64'hfedc_ba98_7654_3210;
    regWrite('h00, 64'h0);
    tx0 = txCount;
    regWrite('h20, 64'd1);
    regRead('h28, v);
    check(v == 1, "R12 accepted command clears error, R2 busy", 128'(v), 1);
    waitIrq(seen);
    check(seen, "R9 interrupt after key load", 128'(seen), 1);
    check(coreKey == {mem[1], mem[0]}, "R3 key halves reach core", coreKey, {mem[1], mem[0]});
    check(lastOp == 2'd0, "R11 set-key operation code", 128'(lastOp), 0);
    check(txCount - tx0 == 2, "R3 two reads for key", 128'(txCount - tx0), 2);
    regRead('h28, v);
    check(v == 0, "R2 idle after key load", 128'(v), 0);
    @(negedge clk);
    check(irq == 1'b0, "R9 status read clears interrupt", 128'(irq), 0);
  endtask

  task automatic runCipher(input int op, input int srcIdx, input int dstIdx, input int n,
                           input string tag);
    bit seen;
    int tx0;
    logic [127:0] exp, got;
    tx0 = txCount;
    setupJob(64'(srcIdx * 8), 64'(dstIdx * 8), n);
    regWrite('h20, 64'(op));
    waitIrq(seen);
    check(seen, {tag, " interrupt at completion"}, 128'(seen), 1);
    check(txCount - tx0 == 4 * n, {tag, " four transfers per block"}, 128'(txCount - tx0), 128'(4 * n));
    check(lastOp == 2'(op - 1), "R11 cipher operation code", 128'(lastOp), 128'(op - 1));
    for (int i = 0; i < n; i++) begin
      exp = (op == 2) ? encF({mem[srcIdx+2*i+1], mem[srcIdx+2*i]}, coreKey)
                      : decF({mem[srcIdx+2*i+1], mem[srcIdx+2*i]}, coreKey);
      got = {mem[dstIdx+2*i+1], mem[dstIdx+2*i]};
      check(got == exp, {tag, " block result at same offset"}, got, exp);
    end
  endtask

  task automatic testEncDec();
    logic [127:0] got, exp;
    for (int i = 0; i < 6; i++) mem[32+i] = 64'h1000_0000_0000_0000 * (i + 1) + 64'(i * 7 + 3);
    runCipher(2, 32, 64, 3, "R4 encrypt");
    runCipher(3, 64, 96, 3, "R4 decrypt");
    for (int i = 0; i < 3; i++) begin
      got = {mem[96+2*i+1], mem[96+2*i]};
      exp = {mem[32+2*i+1], mem[32+2*i]};
      check(got == exp, "R4 decrypt restores plaintext", got, exp);
    end
  endtask

  task automatic testBusyCommand();
    logic [63:0] v;
    bit seen;
    logic [127:0] got, exp;
    for (int i = 0; i < 4; i++) mem[40+i] = 64'hA5A5_0000_0000_0000 + 64'(i);
    for (int i = 0; i < 4; i++) mem[48+i] = '0;
    setupJob(64'(40 * 8), 64'(48 * 8), 2);
    regWrite('h20, 64'd2);
    repeat (3) @(negedge clk);
    regWrite('h20, 64'd3);
    regRead('h28, v);
    check(v == 2, "R5 command while busy sets error", 128'(v), 2);
    waitIrq(seen);
    check(seen, "R5 running job still completes", 128'(seen), 1);
    for (int i = 0; i < 2; i++) begin
      got = {mem[48+2*i+1], mem[48+2*i]};
      exp = encF({mem[40+2*i+1], mem[40+2*i]}, coreKey);
      check(got == exp, "R5 running job results intact", got, exp);
    end
  endtask

  task automatic testZeroCount();
    logic [63:0] v;
    int tx0;
    setupJob(64'h100, 64'h200, 0);
    tx0 = txCount;
    regWrite('h20, 64'd2);
    check(irq == 1'b1, "R8 zero count interrupts next cycle", 128'(irq), 1);
    repeat (5) @(negedge clk);
    check(txCount == tx0, "R8 zero count has no traffic", 128'(txCount), 128'(tx0));
    check(irq == 1'b1, "R9 interrupt holds without clear", 128'(irq), 1);
    regWrite('h20, 64'd0);
    check(irq == 1'b0, "R9 command write clears interrupt", 128'(irq), 0);
    regRead('h28, v);
    check(v == 2, "R7 code zero rejected", 128'(v), 2);
    regWrite('h20, 64'd3);
    regRead('h28, v);
    check(v == 0, "R8 zero count leaves idle status, R12 error cleared", 128'(v), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegisters();
    testNoKey();
    testBadCode();
    testLoadKey();
    testEncDec();
    testBusyCommand();
    testZeroCount();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule